// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the decode stage of an in-order, five-stage pipeline that has operand forwarding. Forwarding cannot help when a load in the execute stage feeds an instruction still in decode, because the loaded value only exists after the memory stage. The block compares the destination index of that load with both source indices of the decoding instruction. On a match it holds the program counter and the fetch/decode register for one cycle and sends a no-op into execute in place of the dependent instruction.

A small sequential shell around the detector holds a program counter, a fetch/decode register and a decode/execute register. With this shell the stall sequence can be observed cycle by cycle at the ports. Instructions enter as decoded fields:
- a memory-read flag
- a register-write flag
- three 5-bit register indices

The bench supplies these fields for the address on `pc`. The execute-stage slot is visible at the outputs and carries its own valid bit and the address the instruction came from.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: A stall cycle (`bubble` = 1, `pc_we` = 0, `ifid_we` = 0) occurs when the execute slot has its memory-read flag set and its rt index equals the rs index of the instruction in decode.
- R2: A match of the execute rt index against the decode rt index also causes a stall. When both decode sources match at the same time, there is still exactly one stall cycle.
- R3: When the execute slot does not read memory, or its rt index matches neither decode source, there is no stall: `pc` advances by 4 at each edge, and decode passes its instruction to execute unchanged. A register-writing instruction that does not read memory never stalls its consumer.
- R4: In a stall cycle `pc` keeps its value across the next clock edge.
- R5: In a stall cycle the fetch/decode register keeps its value. The dependent instruction therefore reaches execute two cycles after the stall, carrying its own address.
- R6: The execute slot that follows a stall cycle is a no-op: `ex_valid`, `ex_memrd` and `ex_regwr` are all 0.
- R7: A load followed by two instructions that use its result gives exactly one stall cycle in an 8-cycle window. The cycle after a stall never stalls.
- R8: A synchronous active-low reset sets `pc` to 0 and loads an all-zero, invalid no-op into both pipeline registers. Reset takes priority over a pending stall.
- R9: When one load feeds a second load, and the second load feeds a third instruction, each dependency costs its own single stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| f_memrd | input | 1 | Fetched instruction reads data memory |
| f_regwr | input | 1 | Fetched instruction writes a register |
| f_rs | input | 5 | Fetched instruction first source index |
| f_rt | input | 5 | Fetched instruction second source / load destination index |
| f_rd | input | 5 | Fetched instruction R-type destination index |
| pc | output | 32 | Current fetch address |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble | output | 1 | Zero the slot entering execute |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_pc | output | 32 | Address of the instruction in execute |
| ex_memrd | output | 1 | Execute slot memory-read flag |
| ex_regwr | output | 1 | Execute slot register-write flag |
| ex_rs | output | 5 | Execute slot rs index |
| ex_rt | output | 5 | Execute slot rt index |
| ex_rd | output | 5 | Execute slot rd index |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two source comparisons. It is provoked by a dependent instruction that names the load's destination as both rs and rt, and it passes only if the run shows a single bubble and the same timing as a one-source match. The second pair is a stall and the synchronous reset. Reset is asserted in the cycle the stall is raised, and the run passes only if the following cycle shows `pc` at 0 with an invalid execute slot and no bubble, rather than a held address.

// File: rtl/ldu_pkg.sv
// Package: shared widths and the pipeline slot type for the load-use stall block.
// Assumes a 32-entry register file (5-bit indices) and byte addresses of 32 bits.
package ldu_pkg;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned PC_W      = 32;
    localparam int unsigned N_SRC     = 2;   // source operands compared per decode slot

    typedef logic [REG_IDX_W-1:0] ridx_t;
    typedef logic [PC_W-1:0]      addr_t;

    // One instruction as it travels down the pipe.
    typedef struct packed {
        logic  vld;
        logic  memrd;
        logic  regwr;
        ridx_t rs;
        ridx_t rt;
        ridx_t rd;
        addr_t pc;
    } slot_t;

    localparam slot_t NOP_SLOT = '0;
endpackage

// File: rtl/ldu_hazard_detect.sv
// Module: combinational load-use detector.
// Compares the execute-stage load destination (rt) against every decode source
// and derives the three pipeline-control outputs. Assumes both inputs come from
// registers, so there is no path from fetch inputs to the controls.
module ldu_hazard_detect
    import ldu_pkg::*;
#(
    parameter int unsigned NSRC = N_SRC
) (
    input  logic                 ex_memrd,
    input  ridx_t                ex_rt,
    input  ridx_t [NSRC-1:0]     id_src,
    output logic                 pc_we,
    output logic                 ifid_we,
    output logic                 bubble
);
    logic [NSRC-1:0] src_hit;
    logic            stall;

    // One equality comparator per decode source operand.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign src_hit[g] = (id_src[g] == ex_rt);
    end

    // Stall decision and the controls it drives.
    always_comb begin
        stall   = ex_memrd && (|src_hit);
        pc_we   = !stall;
        ifid_we = !stall;
        bubble  = stall;
    end
endmodule

// File: rtl/ldu_pc_reg.sv
// Module: program counter with an update enable.
// Steps by STEP when enabled and holds otherwise; the synchronous active-low
// reset clears it to zero.
module ldu_pc_reg
    import ldu_pkg::*;
#(
    parameter int unsigned W    = PC_W,
    parameter int unsigned STEP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    output logic [W-1:0] pc
);
    localparam logic [W-1:0] INC = W'(STEP);

    // Advance or hold the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n)  pc <= '0;
        else if (we) pc <= pc + INC;
    end

    p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (pc == $past(pc)));

    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (pc == $past(pc) + INC));
endmodule

// File: rtl/ldu_ifid_reg.sv
// Module: fetch/decode pipeline register with a write enable.
// Holds its content when the enable is low; reset loads the no-op slot.
module ldu_ifid_reg
    import ldu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  slot_t d,
    output slot_t q
);
    // Capture the fetched instruction unless decode is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= NOP_SLOT;
        else if (we) q <= d;
    end

    p_ifid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (q == $past(q)));
endmodule

// File: rtl/ldu_idex_reg.sv
// Module: decode/execute pipeline register with bubble insertion.
// On bubble the slot entering execute is replaced by the all-zero no-op.
module ldu_idex_reg
    import ldu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bubble,
    input  slot_t d,
    output slot_t q
);
    // Pass the decode slot forward or inject a no-op.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= NOP_SLOT;
        else if (bubble) q <= NOP_SLOT;
        else             q <= d;
    end

    p_bubble_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!q.vld && !q.memrd && !q.regwr));

    p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |=> (q == $past(d)));
endmodule

// File: rtl/ldu_stall_ctrl.sv
// Module: top of the load-use stall controller.
// Joins the detector with the PC, fetch/decode and decode/execute registers.
// Assumes the caller presents the decoded fields of the instruction at `pc`
// in each cycle. The execute slot is exposed at the ports.
module ldu_stall_ctrl
    import ldu_pkg::*;
#(
    parameter int unsigned PC_STEP = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 f_memrd,
    input  logic                 f_regwr,
    input  logic [REG_IDX_W-1:0] f_rs,
    input  logic [REG_IDX_W-1:0] f_rt,
    input  logic [REG_IDX_W-1:0] f_rd,
    output logic [PC_W-1:0]      pc,
    output logic                 pc_we,
    output logic                 ifid_we,
    output logic                 bubble,
    output logic                 ex_valid,
    output logic [PC_W-1:0]      ex_pc,
    output logic                 ex_memrd,
    output logic                 ex_regwr,
    output logic [REG_IDX_W-1:0] ex_rs,
    output logic [REG_IDX_W-1:0] ex_rt,
    output logic [REG_IDX_W-1:0] ex_rd
);
    slot_t            fetch_slot;
    slot_t            id_slot;
    slot_t            ex_slot;
    ridx_t [N_SRC-1:0] id_src;

    // Package the fetched fields with their address into a slot.
    always_comb begin
        fetch_slot       = NOP_SLOT;
        fetch_slot.vld   = 1'b1;
        fetch_slot.memrd = f_memrd;
        fetch_slot.regwr = f_regwr;
        fetch_slot.rs    = f_rs;
        fetch_slot.rt    = f_rt;
        fetch_slot.rd    = f_rd;
        fetch_slot.pc    = pc;
    end

    // Decode source operands in comparator order.
    assign id_src[0] = id_slot.rs;
    assign id_src[1] = id_slot.rt;

    ldu_pc_reg #(.W(PC_W), .STEP(PC_STEP)) u_pc (
        .clk(clk), .rst_n(rst_n), .we(pc_we), .pc(pc)
    );

    ldu_ifid_reg u_ifid (
        .clk(clk), .rst_n(rst_n), .we(ifid_we), .d(fetch_slot), .q(id_slot)
    );

    ldu_idex_reg u_idex (
        .clk(clk), .rst_n(rst_n), .bubble(bubble), .d(id_slot), .q(ex_slot)
    );

    ldu_hazard_detect #(.NSRC(N_SRC)) u_det (
        .ex_memrd(ex_slot.memrd), .ex_rt(ex_slot.rt), .id_src(id_src),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
    );

    // Expose the execute slot.
    always_comb begin
        ex_valid = ex_slot.vld;
        ex_pc    = ex_slot.pc;
        ex_memrd = ex_slot.memrd;
        ex_regwr = ex_slot.regwr;
        ex_rs    = ex_slot.rs;
        ex_rt    = ex_slot.rt;
        ex_rd    = ex_slot.rd;
    end

    p_single_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    p_stall_needs_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> ex_memrd);
endmodule

// File: tb/sim_ldu_stall_ctrl.sv
`timescale 1ns/1ps
module sim_ldu_stall_ctrl;
    localparam time CLK_P = 20ns;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_memrd = 1'b0, f_regwr = 1'b0;
    logic [4:0]  f_rs = '0, f_rt = '0, f_rd = '0;
    logic [31:0] pc, ex_pc;
    logic        pc_we, ifid_we, bubble, ex_valid, ex_memrd, ex_regwr;
    logic [4:0]  ex_rs, ex_rt, ex_rd;

    always #(CLK_P/2) clk = ~clk;

    ldu_stall_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .f_memrd(f_memrd), .f_regwr(f_regwr),
        .f_rs(f_rs), .f_rt(f_rt), .f_rd(f_rd), .pc(pc), .pc_we(pc_we),
        .ifid_we(ifid_we), .bubble(bubble), .ex_valid(ex_valid), .ex_pc(ex_pc),
        .ex_memrd(ex_memrd), .ex_regwr(ex_regwr), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_rd(ex_rd)
    );

    typedef struct {
        logic [31:0] pc;
        logic        pcwe, ifwe, bub, exv;
        logic [31:0] expc;
        logic        exmr, exrw;
        string       tag;
    } exp_t;

    exp_t expq[$];
    exp_t cur;
    int   n_tests = 0, n_fail = 0, n_bub = 0;
    bit   mon_en = 1'b0, done = 1'b0;

    logic       p_mr[16], p_rw[16];
    logic [4:0] p_rs[16], p_rt[16], p_rd[16];

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) begin
            p_mr[i] = 0; p_rw[i] = 0; p_rs[i] = 0; p_rt[i] = 0; p_rd[i] = 0;
        end
    endtask

    task automatic set_ins(int a, logic mr, logic rw, int rs, int rt, int rd);
        p_mr[a] = mr; p_rw[a] = rw;
        p_rs[a] = 5'(rs); p_rt[a] = 5'(rt); p_rd[a] = 5'(rd);
    endtask

    // Driver side of the scoreboard: one expected item per cycle.
    task automatic push(int epc, bit pw, bit iw, bit bb, bit v, int xpc, bit mr, bit rw, string tag);
        exp_t e;
        e.pc = 32'(epc); e.pcwe = pw; e.ifwe = iw; e.bub = bb; e.exv = v;
        e.expc = 32'(xpc); e.exmr = mr; e.exrw = rw; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic chk(bit ok, string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Fetch side: present the instruction at the current address.
    initial begin
        forever begin
            @(negedge clk);
            begin
                automatic int i = int'(pc >> 2);
                if (i < 16) begin
                    f_memrd = p_mr[i]; f_regwr = p_rw[i];
                    f_rs = p_rs[i]; f_rt = p_rt[i]; f_rd = p_rd[i];
                end else begin
                    f_memrd = 0; f_regwr = 0; f_rs = 0; f_rt = 0; f_rd = 0;
                end
            end
        end
    end

    // Monitor: pop one expectation per cycle and compare.
    always @(negedge clk) begin
        #1;
        if (mon_en && expq.size() > 0) begin
            cur = expq.pop_front();
            if (bubble === 1'b1) n_bub++;
            n_tests++;
            if (pc !== cur.pc || pc_we !== cur.pcwe || ifid_we !== cur.ifwe ||
                bubble !== cur.bub || ex_valid !== cur.exv ||
                (cur.exv && (ex_pc !== cur.expc || ex_memrd !== cur.exmr || ex_regwr !== cur.exrw)) ||
                (!cur.exv && (ex_memrd !== 1'b0 || ex_regwr !== 1'b0))) begin
                n_fail++;
                $display("FAIL %s: got pc=%0d pcwe=%b ifwe=%b bub=%b exv=%b expc=%0d mr=%b rw=%b; exp pc=%0d pcwe=%b ifwe=%b bub=%b exv=%b expc=%0d mr=%b rw=%b",
                    cur.tag, pc, pc_we, ifid_we, bubble, ex_valid, ex_pc, ex_memrd, ex_regwr,
                    cur.pc, cur.pcwe, cur.ifwe, cur.bub, cur.exv, cur.expc, cur.exmr, cur.exrw);
            end
        end
    end

    // Reset, check the cleared state (R8), then let the queued cycles play out.
    task automatic run_scn(string name);
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pc == 0 && !ex_valid && !bubble && pc_we && ifid_we,
            $sformatf("R8 %s reset: pc=%0d exv=%b bub=%b pcwe=%b exp pc=0 exv=0 bub=0 pcwe=1",
                      name, pc, ex_valid, bubble, pc_we));
        n_bub = 0;
        mon_en = 1;
        rst_n = 1;
        wait (expq.size() == 0);
        @(negedge clk);
        mon_en = 0;
    endtask

    // Shape shared by a single load-use stall with lw at 0 and its user at 4.
    task automatic push_one_stall(string t);
        push(0, 1,1,0,0, 0, 0,0, {t, " k0"});
        push(4, 1,1,0,0, 0, 0,0, {t, " k1"});
        push(8, 0,0,1,1, 0, 1,1, {t, " k2 stall"});
        push(8, 1,1,0,0, 0, 0,0, {t, " k3 bubble R6 R4"});
        push(12,1,1,0,1, 4, 0,1, {t, " k4 user R5"});
    endtask

    initial begin
        // R1 R7: lw r8; add r10=r8+r11; sub r12=r10-r8
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 0,1, 8,11,10);
        set_ins(2, 0,1, 10,8,12);
        push_one_stall("R1");
        push(16,1,1,0,1, 8, 0,1, "R7 k5 second user no stall");
        push(20,1,1,0,1, 12,0,0, "R7 k6");
        push(24,1,1,0,1, 16,0,0, "R7 k7");
        run_scn("R1");
        chk(n_bub == 1, $sformatf("R7 bubbles in 8 cycles: got %0d exp 1", n_bub));

        // R2: match on decode rt only
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 0,1, 3,8,10);
        push_one_stall("R2 rt");
        run_scn("R2rt");
        chk(n_bub == 1, $sformatf("R2 rt bubbles: got %0d exp 1", n_bub));

        // R2: both decode sources match in the same cycle
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 0,1, 8,8,10);
        push_one_stall("R2 both");
        push(16,1,1,0,1, 8, 0,0, "R2 both k5");
        run_scn("R2both");
        chk(n_bub == 1, $sformatf("R2 both bubbles: got %0d exp 1", n_bub));

        // R3: load with no dependent instruction
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 0,1, 6,7,10);
        push(0, 1,1,0,0, 0, 0,0, "R3 nodep k0");
        push(4, 1,1,0,0, 0, 0,0, "R3 nodep k1");
        push(8, 1,1,0,1, 0, 1,1, "R3 nodep k2");
        push(12,1,1,0,1, 4, 0,1, "R3 nodep k3");
        push(16,1,1,0,1, 8, 0,0, "R3 nodep k4");
        run_scn("R3nodep");
        chk(n_bub == 0, $sformatf("R3 nodep bubbles: got %0d exp 0", n_bub));

        // R3: register-writing non-load producer with matching rt
        clear_prog();
        set_ins(0, 0,1, 4,8,8);
        set_ins(1, 0,1, 8,8,10);
        push(0, 1,1,0,0, 0, 0,0, "R3 alu k0");
        push(4, 1,1,0,0, 0, 0,0, "R3 alu k1");
        push(8, 1,1,0,1, 0, 0,1, "R3 alu k2");
        push(12,1,1,0,1, 4, 0,1, "R3 alu k3");
        run_scn("R3alu");
        chk(n_bub == 0, $sformatf("R3 alu bubbles: got %0d exp 0", n_bub));

        // R9: lw r8; lw r9,(r8); add r3=r9+r2
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 1,1, 8,9,0);
        set_ins(2, 0,1, 9,2,3);
        push(0, 1,1,0,0, 0, 0,0, "R9 k0");
        push(4, 1,1,0,0, 0, 0,0, "R9 k1");
        push(8, 0,0,1,1, 0, 1,1, "R9 k2 stall1");
        push(8, 1,1,0,0, 0, 0,0, "R9 k3 bubble1");
        push(12,0,0,1,1, 4, 1,1, "R9 k4 stall2");
        push(12,1,1,0,0, 0, 0,0, "R9 k5 bubble2");
        push(16,1,1,0,1, 8, 0,1, "R9 k6 user");
        push(20,1,1,0,1, 12,0,0, "R9 k7");
        run_scn("R9");
        chk(n_bub == 2, $sformatf("R9 bubbles: got %0d exp 2", n_bub));

        // R8: reset asserted in the stall cycle wins over the hold
        clear_prog();
        set_ins(0, 1,1, 9,8,0);
        set_ins(1, 0,1, 8,11,10);
        push(0, 1,1,0,0, 0, 0,0, "R8 k0");
        push(4, 1,1,0,0, 0, 0,0, "R8 k1");
        push(8, 0,0,1,1, 0, 1,1, "R8 k2 stall");
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mon_en = 1;
        rst_n = 1;
        wait (expq.size() == 0);
        mon_en = 0;
        rst_n = 0;
        @(negedge clk);
        chk(pc == 0 && !ex_valid && !bubble && pc_we,
            $sformatf("R8 reset over stall: pc=%0d exv=%b bub=%b pcwe=%b exp pc=0 exv=0 bub=0 pcwe=1",
                      pc, ex_valid, bubble, pc_we));
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule